// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Output Stage

This block is a first-in first-out buffer on one clock. A word on `wr_data` is stored when `wr_en` is high and the buffer is not full. The oldest stored word is taken out when `rd_en` is high and the buffer is not empty. Four status flags report the fill level: `empty`, `full`, `almost_empty` and `almost_full`. The two "almost" thresholds are parameters. A synchronous reset returns the buffer to an empty state.

The storage has a registered read port. In the default behaviour a word taken out at one clock edge is on `rd_q` right after that edge. The parameter `OUT_MODE` selects one of three output stages after that port. `OQ_BYPASS` adds no stage. `OQ_PIPE` adds a register that loads at every edge, so `rd_q` arrives one clock later. `OQ_GATED` adds a register that loads only at edges where `rd_en` is high and keeps its value at all other edges. The flags come only from the occupancy count, so they change on the same edges in all three modes. Only the data path gets longer.

The fill controller is a three-state machine:
- `FILL_EMPTY` goes to `FILL_PARTIAL` on any accepted write.
- `FILL_PARTIAL` goes to `FILL_EMPTY` when one word is left and a read is accepted with no write.
- `FILL_PARTIAL` goes to `FILL_FULL` when one free slot is left and a write is accepted with no read.
- `FILL_FULL` goes to `FILL_PARTIAL` on any accepted read.
- In every other case the state holds.
- Reset forces `FILL_EMPTY`.

Top module: `sync_fifo_oreg`

## Requirements
- R1: While `rst` is sampled high at a clock edge, after that edge the flags read `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0, and `rd_q`=0. Zero marks "no valid data yet".
- R2: With `OUT_MODE`=`OQ_BYPASS`, a read accepted at an edge puts the oldest stored word on `rd_q` right after that edge. Words leave in the order they were written.
- R3: A write while `full` and a read while `empty` are ignored. Storage contents, read order and flags are the same as if the request had not been made.
- R4: `empty` is high exactly when the occupancy is 0. `full` is high exactly when the occupancy is `DEPTH`. Both flags change right after the edge that changes the occupancy.
- R5: `almost_empty` is high exactly when the occupancy is at or below `AE_LEVEL`. `almost_full` is high exactly when the occupancy is at or above `AF_LEVEL`.
- R6: A read and a write at the same edge, with the buffer neither empty nor full, leave the occupancy and all flags unchanged.
- R7: With `OUT_MODE`=`OQ_PIPE`, `rd_q` after each edge equals the value the bypass output had before that edge. This is one clock more latency.
- R8: With `OUT_MODE`=`OQ_GATED`, `rd_q` loads the storage read word only at edges where `rd_en` is high, whether or not the read is accepted. At every other edge `rd_q` holds its value.
- R9: The four flags are the same on every cycle for all three values of `OUT_MODE` under the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_WIDTH | Word to store |
| rd_en | input | 1 | Read request; in `OQ_GATED` mode it also loads the output register |
| rd_q | output | DATA_WIDTH | Read data |
| empty | output | 1 | Occupancy is zero |
| almost_empty | output | 1 | Occupancy is at or below `AE_LEVEL` |
| full | output | 1 | Occupancy is `DEPTH` |
| almost_full | output | 1 | Occupancy is at or above `AF_LEVEL` |

## Verification
The hardest case to reach from the ports is the gated output register while read requests are turned away. The register must still load at edges where `rd_en` is high even when the buffer is empty, and must hold through long stretches with `rd_en` low after the storage read word has already changed. The bench drives three instances, one per output mode, with the same stimulus. It drains the buffer fully, keeps issuing reads against the empty buffer, and then mixes random `rd_en` pulses with idle gaps at a low fill level. Directed passes push the fill level to exactly `DEPTH` and back to zero, so both boundary transitions of the state machine and the ignored requests are exercised.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

    typedef enum logic [1:0] {
        FILL_EMPTY   = 2'd0,
        FILL_PARTIAL = 2'd1,
        FILL_FULL    = 2'd2
    } fill_state_e;

    typedef enum logic [1:0] {
        OQ_BYPASS = 2'd0,
        OQ_PIPE   = 2'd1,
        OQ_GATED  = 2'd2
    } oq_mode_e;

endpackage

// File: rtl/sfq_ctrl.sv
module sfq_ctrl
    import sfq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int AE_LEVEL = 2,
    parameter int AF_LEVEL = 14,
    localparam int AW      = $clog2(DEPTH),
    localparam int CW      = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          wr_go,
    output logic          rd_go,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] occ,
    output logic          empty,
    output logic          full,
    output logic          almost_empty,
    output logic          almost_full
);

    localparam logic [CW-1:0] OCC_ONE  = CW'(1);
    localparam logic [CW-1:0] OCC_LAST = CW'(DEPTH - 1);
    localparam logic [CW-1:0] AE_C     = CW'(AE_LEVEL);
    localparam logic [CW-1:0] AF_C     = CW'(AF_LEVEL);

    fill_state_e  state_q, state_d;
    logic [CW-1:0] occ_d;

    // request acceptance depends only on the fill state
    always_comb begin
        wr_go = wr_en && (state_q != FILL_FULL);
        rd_go = rd_en && (state_q != FILL_EMPTY);
    end

    // next occupancy
    always_comb begin
        unique case ({wr_go, rd_go})
            2'b10:   occ_d = occ + OCC_ONE;
            2'b01:   occ_d = occ - OCC_ONE;
            default: occ_d = occ;
        endcase
    end

    // next fill state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_EMPTY: begin
                if (wr_go)
                    state_d = (OCC_LAST == '0) ? FILL_FULL : FILL_PARTIAL;
            end
            FILL_PARTIAL: begin
                if (rd_go && !wr_go && occ == OCC_ONE)
                    state_d = FILL_EMPTY;
                else if (wr_go && !rd_go && occ == OCC_LAST)
                    state_d = FILL_FULL;
            end
            FILL_FULL: begin
                if (rd_go)
                    state_d = (OCC_LAST == '0) ? FILL_EMPTY : FILL_PARTIAL;
            end
            default: state_d = FILL_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= FILL_EMPTY;
        else
            state_q <= state_d;
    end

    // pointers and occupancy
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (wr_go) wr_ptr <= wr_ptr + AW'(1);
            if (rd_go) rd_ptr <= rd_ptr + AW'(1);
            occ <= occ_d;
        end
    end

    // outputs from state and count
    always_comb begin
        empty        = 1'b0;
        full         = 1'b0;
        unique case (state_q)
            FILL_EMPTY:   empty = 1'b1;
            FILL_PARTIAL: ;
            FILL_FULL:    full  = 1'b1;
            default:      empty = 1'b1;
        endcase
        almost_empty = (occ <= AE_C);
        almost_full  = (occ >= AF_C);
    end

endmodule

// File: rtl/sfq_store.sv
module sfq_store #(
    parameter int DATA_WIDTH = 8,
    parameter int DEPTH      = 16,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_go,
    input  logic [AW-1:0]         wr_addr,
    input  logic [DATA_WIDTH-1:0] wr_data,
    input  logic                  rd_go,
    input  logic [AW-1:0]         rd_addr,
    output logic [DATA_WIDTH-1:0] rd_word
);

    logic [DATA_WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_go)
            cells[wr_addr] <= wr_data;
    end

    // registered read port: the word appears after the accepting edge
    always_ff @(posedge clk) begin
        if (rst)
            rd_word <= '0;
        else if (rd_go)
            rd_word <= cells[rd_addr];
    end

endmodule

// File: rtl/sfq_ostage.sv
module sfq_ostage
    import sfq_pkg::*;
#(
    parameter int       DATA_WIDTH = 8,
    parameter oq_mode_e OUT_MODE   = OQ_GATED
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_en,
    input  logic [DATA_WIDTH-1:0] mem_q,
    output logic [DATA_WIDTH-1:0] q
);

    generate
        if (OUT_MODE == OQ_BYPASS) begin : g_bypass
            assign q = mem_q;
        end else if (OUT_MODE == OQ_PIPE) begin : g_pipe
            logic [DATA_WIDTH-1:0] q_r;
            always_ff @(posedge clk) begin
                if (rst) q_r <= '0;
                else     q_r <= mem_q;
            end
            assign q = q_r;
        end else begin : g_gated
            logic [DATA_WIDTH-1:0] q_r;
            always_ff @(posedge clk) begin
                if (rst)        q_r <= '0;
                else if (rd_en) q_r <= mem_q;
            end
            assign q = q_r;
        end
    endgenerate

endmodule

// File: rtl/sync_fifo_oreg.sv
module sync_fifo_oreg
    import sfq_pkg::*;
#(
    parameter int       DATA_WIDTH = 8,
    parameter int       DEPTH      = 16,
    parameter int       AE_LEVEL   = 2,
    parameter int       AF_LEVEL   = 14,
    parameter oq_mode_e OUT_MODE   = OQ_GATED
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [DATA_WIDTH-1:0] wr_data,
    input  logic                  rd_en,
    output logic [DATA_WIDTH-1:0] rd_q,
    output logic                  empty,
    output logic                  almost_empty,
    output logic                  full,
    output logic                  almost_full
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic                  wr_go, rd_go;
    logic [AW-1:0]         wr_ptr, rd_ptr;
    logic [CW-1:0]         occ;
    logic [DATA_WIDTH-1:0] mem_q;

    sfq_ctrl #(
        .DEPTH   (DEPTH),
        .AE_LEVEL(AE_LEVEL),
        .AF_LEVEL(AF_LEVEL)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .wr_go       (wr_go),
        .rd_go       (rd_go),
        .wr_ptr      (wr_ptr),
        .rd_ptr      (rd_ptr),
        .occ         (occ),
        .empty       (empty),
        .full        (full),
        .almost_empty(almost_empty),
        .almost_full (almost_full)
    );

    sfq_store #(
        .DATA_WIDTH(DATA_WIDTH),
        .DEPTH     (DEPTH)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_go  (wr_go),
        .wr_addr(wr_ptr),
        .wr_data(wr_data),
        .rd_go  (rd_go),
        .rd_addr(rd_ptr),
        .rd_word(mem_q)
    );

    sfq_ostage #(
        .DATA_WIDTH(DATA_WIDTH),
        .OUT_MODE  (OUT_MODE)
    ) u_ostage (
        .clk  (clk),
        .rst  (rst),
        .rd_en(rd_en),
        .mem_q(mem_q),
        .q    (rd_q)
    );

endmodule

// File: rtl/sfq_chk.sv
module sfq_chk
    import sfq_pkg::*;
#(
    parameter int       DATA_WIDTH = 8,
    parameter int       DEPTH      = 16,
    parameter int       AE_LEVEL   = 2,
    parameter int       AF_LEVEL   = 14,
    parameter oq_mode_e OUT_MODE   = OQ_GATED,
    localparam int      CW         = $clog2(DEPTH) + 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [DATA_WIDTH-1:0] rd_q,
    input logic [DATA_WIDTH-1:0] mem_q,
    input logic [CW-1:0]         occ,
    input logic                  empty,
    input logic                  almost_empty,
    input logic                  full,
    input logic                  almost_full
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (empty && almost_empty && !full && !almost_full && rd_q == '0));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> (full && $stable(occ)));

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> (empty && $stable(occ)));

    p_flag_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    p_empty_ae_r5: assert property (@(posedge clk) disable iff (rst)
        empty |-> almost_empty);

    p_full_af_r5: assert property (@(posedge clk) disable iff (rst)
        full |-> almost_full);

    p_rw_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && !empty && !full) |=> ($stable(occ) && $stable(almost_empty) && $stable(almost_full)));

    generate
        if (OUT_MODE == OQ_BYPASS) begin : g_bypass
            p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
                rd_q == mem_q);
        end else if (OUT_MODE == OQ_PIPE) begin : g_pipe
            p_oreg_lag_r7: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> rd_q == $past(mem_q));
        end else begin : g_gated
            p_gate_load_r8: assert property (@(posedge clk) disable iff (rst)
                rd_en |=> rd_q == $past(mem_q));
            p_gate_hold_r8: assert property (@(posedge clk) disable iff (rst)
                !rd_en |=> $stable(rd_q));
        end
    endgenerate

endmodule

bind sync_fifo_oreg sfq_chk #(
    .DATA_WIDTH(DATA_WIDTH),
    .DEPTH     (DEPTH),
    .AE_LEVEL  (AE_LEVEL),
    .AF_LEVEL  (AF_LEVEL),
    .OUT_MODE  (OUT_MODE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .rd_q        (rd_q),
    .mem_q       (mem_q),
    .occ         (occ),
    .empty       (empty),
    .almost_empty(almost_empty),
    .full        (full),
    .almost_full (almost_full)
);

// File: tb/sync_fifo_oreg_bench.sv
`timescale 1ns/1ps
module sync_fifo_oreg_bench;
    import sfq_pkg::*;

    localparam int DW = 8;
    localparam int DP = 16;
    localparam int AE = 2;
    localparam int AF = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;

    logic [DW-1:0] q0, q1, q2;
    logic e0, ae0, f0, af0;
    logic e1, ae1, f1, af1;
    logic e2, ae2, f2, af2;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sync_fifo_oreg #(.DATA_WIDTH(DW), .DEPTH(DP), .AE_LEVEL(AE), .AF_LEVEL(AF), .OUT_MODE(OQ_BYPASS))
    u_sync_fifo_oreg (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_q(q0), .empty(e0), .almost_empty(ae0), .full(f0), .almost_full(af0));

    sync_fifo_oreg #(.DATA_WIDTH(DW), .DEPTH(DP), .AE_LEVEL(AE), .AF_LEVEL(AF), .OUT_MODE(OQ_PIPE))
    u_sync_fifo_oreg_pipe (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_q(q1), .empty(e1), .almost_empty(ae1), .full(f1), .almost_full(af1));

    sync_fifo_oreg #(.DATA_WIDTH(DW), .DEPTH(DP), .AE_LEVEL(AE), .AF_LEVEL(AF), .OUT_MODE(OQ_GATED))
    u_sync_fifo_oreg_gated (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_q(q2), .empty(e2), .almost_empty(ae2), .full(f2), .almost_full(af2));

    // reference model
    logic [DW-1:0] m_cells [DP];
    int m_wp = 0, m_rp = 0, m_cnt = 0;
    logic [DW-1:0] m_rd = '0, m_q1 = '0, m_q2 = '0;

    function automatic bit exp_empty(int c); return c == 0;   endfunction
    function automatic bit exp_full(int c);  return c == DP;  endfunction
    function automatic bit exp_ae(int c);    return c <= AE;  endfunction
    function automatic bit exp_af(int c);    return c >= AF;  endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h @%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(e0 == exp_empty(m_cnt), "R4", {tag, " empty"}, int'(e0), int'(exp_empty(m_cnt)));
        chk(f0 == exp_full(m_cnt),  "R4", {tag, " full"},  int'(f0), int'(exp_full(m_cnt)));
        chk(ae0 == exp_ae(m_cnt),   "R5", {tag, " almost_empty"}, int'(ae0), int'(exp_ae(m_cnt)));
        chk(af0 == exp_af(m_cnt),   "R5", {tag, " almost_full"},  int'(af0), int'(exp_af(m_cnt)));
        chk({e1, f1, ae1, af1} == {e0, f0, ae0, af0}, "R9", {tag, " pipe flags"},
            int'({e1, f1, ae1, af1}), int'({e0, f0, ae0, af0}));
        chk({e2, f2, ae2, af2} == {e0, f0, ae0, af0}, "R9", {tag, " gated flags"},
            int'({e2, f2, ae2, af2}), int'({e0, f0, ae0, af0}));
        chk(q0 == m_rd, "R2", {tag, " bypass q"}, int'(q0), int'(m_rd));
        chk(q1 == m_q1, "R7", {tag, " pipe q"},   int'(q1), int'(m_q1));
        chk(q2 == m_q2, "R8", {tag, " gated q"},  int'(q2), int'(m_q2));
    endtask

    // drive at negedge, model after posedge, compare at next negedge
    task automatic step(input bit w, input bit r, input logic [DW-1:0] d, input string tag);
        bit acc_w, acc_r;
        wr_en = w; rd_en = r; wr_data = d;
        @(posedge clk);
        acc_r = r && (m_cnt > 0);
        acc_w = w && (m_cnt < DP);
        m_q1 = m_rd;
        if (r) m_q2 = m_rd;
        if (acc_r) begin
            m_rd = m_cells[m_rp];
            m_rp = (m_rp + 1) % DP;
        end
        if (acc_w) begin
            m_cells[m_wp] = d;
            m_wp = (m_wp + 1) % DP;
        end
        m_cnt = m_cnt + int'(acc_w) - int'(acc_r);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic do_reset();
        wr_en = 0; rd_en = 0; rst = 1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        m_wp = 0; m_rp = 0; m_cnt = 0; m_rd = '0; m_q1 = '0; m_q2 = '0;
        chk(e0 && ae0 && !f0 && !af0, "R1", "reset flags", int'({e0, ae0, f0, af0}), 4'b1100);
        chk(q0 == '0 && q1 == '0 && q2 == '0, "R1", "reset q", int'({q0, q1, q2}), 0);
        rst = 0;
    endtask

    initial begin
        void'($urandom(32'h5EED_0F1F));
        @(negedge clk);
        do_reset();

        // R4/R5: fill to exactly DEPTH, then R3: write while full ignored
        for (int i = 0; i < DP; i++) step(1, 0, DW'(8'h10 + i), "fill R4 R5");
        chk(f0 == 1'b1, "R4", "full after DEPTH writes", int'(f0), 1);
        step(1, 0, 8'hEE, "R3 write while full");
        chk(f0 == 1'b1 && af0 == 1'b1, "R3", "still full", int'({f0, af0}), 3);
        // R6 cannot apply at full; read+write at full: read accepted only
        step(1, 1, 8'hEF, "rw at full");
        // drain; order proves the 0xEE write was dropped
        for (int i = 0; i < DP + 2; i++) step(0, 1, '0, "drain R2 R3");
        chk(e0 == 1'b1, "R3", "empty after drain", int'(e0), 1);
        // R3: reads while empty, then one write and read
        step(0, 1, '0, "R3 read while empty");
        step(0, 0, '0, "idle");
        step(1, 0, 8'hA5, "R3 single write");
        step(0, 1, '0, "R3 single read");
        chk(q0 == 8'hA5, "R3", "word after ignored reads", int'(q0), 8'hA5);
        step(0, 0, '0, "idle");
        // R6: occupancy held through simultaneous read and write above AE
        for (int i = 0; i < AE + 1; i++) step(1, 0, DW'(8'h40 + i), "prefill R6");
        for (int i = 0; i < 6; i++) begin
            step(1, 1, DW'(8'h50 + i), "R6 rw");
            chk(ae0 == 1'b0 && e0 == 1'b0, "R6", "flags hold on rw", int'({ae0, e0}), 0);
        end
        // R8: hold when rd_en low for several cycles
        step(0, 1, '0, "R8 load");
        for (int i = 0; i < 4; i++) step(0, 0, '0, "R8 hold");
        // mid-run reset
        do_reset();

        // random phases with differing bias
        for (int ph = 0; ph < 3; ph++) begin
            for (int i = 0; i < 1500; i++) begin
                int wb, rb;
                wb = (ph == 0) ? 70 : (ph == 1) ? 30 : 50;
                rb = (ph == 0) ? 30 : (ph == 1) ? 70 : 50;
                step($urandom_range(0, 99) < wb, $urandom_range(0, 99) < rb,
                     DW'($urandom), "random");
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule